// File: doc/BRIEF.md
# Deflection Protection Sequencer

This block watches four fault comparators of a monitor deflection controller. Any active fault puts the controller into standby. In standby the power and deflection outputs float, the picture is blanked, and the phase-locked-loop filter capacitor is discharged.

Each fault cause is latched on its own and has its own recovery rule. Depending on the cause, recovery can need:
- the supply to come back,
- a register reload,
- a soft-start command written over I2C,
- or only the release of the fault pin.

The block stays protected until every latched cause has met its own rule. It then brings the outputs back one at a time in a fixed order. Two programmable delays space the steps of that order.

A fault that appears during the release steps sends the block straight back to full protection. The block comes out of reset as if the supply had been low. A fresh start-up therefore needs a register reload followed by a soft-start command.

Top module: `prot_seq`

## Requirements
- R1: During reset and after reset release, the outputs hold the safe set: `dischg_on`=1, `blank_on`=1, and `hdrv_oe`, `bdrv_oe`, `vout_oe`, `unlock_oe` all 0. They stay in the safe set until the start-up recovery of R3 is complete, because reset counts as a latched low-supply cause.
- R2: If any fault input is 1 at a rising clock edge, the outputs are in the safe set from that edge on, whatever step they were in.
- R3: A latched low-supply cause clears only when all three of these hold:
  - `flt_supply_low` is 0;
  - a `regs_reloaded` pulse was seen in an earlier cycle, after every fault input went low;
  - `i2c_soft_start` is 1.
  A soft-start command without a qualifying reload is ignored.
- R4: A latched supply-dip cause clears once `flt_supply_dip` is 0 and a qualifying reload has been seen. No soft-start command is needed.
- R5: A latched X-ray cause stays latched after `flt_xray` returns to 0 and a reload arrives. It clears only on a soft-start command after a qualifying reload.
- R6: A filter-pin-grounded cause clears as soon as `flt_pll_gnd` returns to 0, with no reload and no soft-start command.
- R7: With several causes latched, protection holds until every cause has met its own rule.
- R8: Release order, counted from the edge where the last cause clears:
  1. `dischg_on` drops with blanking still on, and this state lasts `cfg_blank_hold` cycles.
  2. `hdrv_oe` rises, then `bdrv_oe` rises `cfg_step_dly` cycles later.
  3. `vout_oe` rises a further `cfg_step_dly` cycles later.
  4. `unlock_oe` rises and `blank_on` drops together a further `cfg_step_dly` cycles later.
- R9: A delay setting of 0 behaves as a delay of one cycle.
- R10: A `regs_reloaded` pulse that arrives while any fault input is 1 does not count toward recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flt_supply_low | input | 1 | Supply below operating level (synchronous comparator flag) |
| flt_supply_dip | input | 1 | Supply dipped below the dip threshold |
| flt_xray | input | 1 | X-ray protection trip |
| flt_pll_gnd | input | 1 | Filter pin of the second phase loop held to ground |
| i2c_soft_start | input | 1 | Soft-start command from the control register, one-cycle pulse |
| regs_reloaded | input | 1 | Pulse: the setting registers have been rewritten |
| cfg_blank_hold | input | DLY_W | Cycles of blanking between discharge off and horizontal driver on |
| cfg_step_dly | input | DLY_W | Cycles between the later release steps |
| hdrv_oe | output | 1 | Horizontal driver enable (0 = floating) |
| bdrv_oe | output | 1 | B+ driver enable (0 = floating) |
| vout_oe | output | 1 | Vertical outputs enable (0 = floating) |
| unlock_oe | output | 1 | Unlock flag driven (0 = floating, read high) |
| blank_on | output | 1 | Continuous blanking forced |
| dischg_on | output | 1 | Filter capacitor discharge switch on |

## Verification
A cause flag that is latched wrongly shows up at once at the ports. If it is stuck set, the block never leaves the safe set. If it clears too early, `dischg_on` drops a cycle after a stimulus that should have been ignored. A wrong release step or a bad delay counter shows up as an enable rising one or more cycles early or late in the R8 order. The bench checks the outputs on the exact cycle before and after each expected change. A lost reload qualifier shows up as a missed or a spurious exit from protection on the soft-start pulse that follows.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

  // release steps, ordered so that later steps compare greater
  typedef enum logic [2:0] {
    ST_PROT  = 3'd0,
    ST_DISCH = 3'd1,
    ST_HDRV  = 3'd2,
    ST_BDRV  = 3'd3,
    ST_VOUT  = 3'd4,
    ST_RUN   = 3'd5
  } rel_state_e;

  localparam int unsigned N_CAUSE = 4;
  localparam int unsigned CZ_LOW  = 0;
  localparam int unsigned CZ_DIP  = 1;
  localparam int unsigned CZ_XRAY = 2;
  localparam int unsigned CZ_PLL  = 3;

  // per-cause recovery rule: bit set = condition required
  localparam logic [N_CAUSE-1:0] NEED_RELOAD = 4'b0111;
  localparam logic [N_CAUSE-1:0] NEED_SOFT   = 4'b0101;

  // reset behaves as a latched low-supply cause
  localparam logic [N_CAUSE-1:0] CAUSE_AT_RESET = 4'b0001;

endpackage

// File: rtl/prot_rst_sync.sv
module prot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/prot_cause_latch.sv
module prot_cause_latch
  import prot_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] flt,
  input  logic               soft_start,
  input  logic               reloaded,
  output logic               any_cause_d
);

  logic [N_CAUSE-1:0] cause_q, cause_d, clr;
  logic               rld_seen_q, rld_seen_d;
  logic               any_flt, recovering;

  assign any_flt = |flt;

  // each cause applies its own recovery rule
  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    assign clr[i]     = !flt[i]
                        && (!NEED_RELOAD[i] || rld_seen_q)
                        && (!NEED_SOFT[i]   || soft_start);
    assign cause_d[i] = flt[i] || (cause_q[i] && !clr[i]);
  end

  assign recovering  = (|cause_q) && !(|cause_d);
  assign any_cause_d = |cause_d;

  always_comb begin
    rld_seen_d = rld_seen_q;
    if (any_flt || recovering) rld_seen_d = 1'b0;
    else if (reloaded)         rld_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q    <= CAUSE_AT_RESET;
      rld_seen_q <= 1'b0;
    end else begin
      cause_q    <= cause_d;
      rld_seen_q <= rld_seen_d;
    end
  end

endmodule

// File: rtl/prot_step_timer.sv
module prot_step_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DLY_W-1:0] dly,
  output logic             done
);

  localparam int unsigned CW = DLY_W + 1;

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          cnt_en;

  assign cnt_inc = cnt_q + CW'(1);
  // dwell is max(dly,1) cycles
  assign done    = cnt_inc >= {1'b0, dly};
  assign cnt_en  = clr || !done;
  assign cnt_d   = clr ? '0 : cnt_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/prot_release_fsm.sv
module prot_release_fsm
  import prot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_cause_d,
  input  logic       step_done,
  output rel_state_e state_q,
  output logic       tmr_clr,
  output logic       hdrv_oe,
  output logic       bdrv_oe,
  output logic       vout_oe,
  output logic       unlock_oe,
  output logic       blank_on,
  output logic       dischg_on
);

  rel_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (any_cause_d) begin
      state_d = ST_PROT;
    end else begin
      case (state_q)
        ST_PROT:  state_d = ST_DISCH;
        ST_DISCH: if (step_done) state_d = ST_HDRV;
        ST_HDRV:  if (step_done) state_d = ST_BDRV;
        ST_BDRV:  if (step_done) state_d = ST_VOUT;
        ST_VOUT:  if (step_done) state_d = ST_RUN;
        ST_RUN:   state_d = ST_RUN;
        default:  state_d = ST_PROT;
      endcase
    end
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PROT;
    else        state_q <= state_d;
  end

  assign dischg_on = (state_q == ST_PROT);
  assign blank_on  = (state_q != ST_RUN);
  assign hdrv_oe   = (state_q >= ST_HDRV);
  assign bdrv_oe   = (state_q >= ST_BDRV);
  assign vout_oe   = (state_q >= ST_VOUT);
  assign unlock_oe = (state_q == ST_RUN);

endmodule

// File: rtl/prot_seq.sv
module prot_seq
  import prot_seq_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_supply_low,
  input  logic             flt_supply_dip,
  input  logic             flt_xray,
  input  logic             flt_pll_gnd,
  input  logic             i2c_soft_start,
  input  logic             regs_reloaded,
  input  logic [DLY_W-1:0] cfg_blank_hold,
  input  logic [DLY_W-1:0] cfg_step_dly,
  output logic             hdrv_oe,
  output logic             bdrv_oe,
  output logic             vout_oe,
  output logic             unlock_oe,
  output logic             blank_on,
  output logic             dischg_on
);

  logic               rst_i_n;
  logic [N_CAUSE-1:0] flt;
  logic               any_cause_d;
  logic               step_done, tmr_clr;
  logic [DLY_W-1:0]   cur_dly;
  rel_state_e         state_q;

  always_comb begin
    flt          = '0;
    flt[CZ_LOW]  = flt_supply_low;
    flt[CZ_DIP]  = flt_supply_dip;
    flt[CZ_XRAY] = flt_xray;
    flt[CZ_PLL]  = flt_pll_gnd;
  end

  prot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  prot_cause_latch u_cause (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .flt         (flt),
    .soft_start  (i2c_soft_start),
    .reloaded    (regs_reloaded),
    .any_cause_d (any_cause_d)
  );

  assign cur_dly = (state_q == ST_DISCH) ? cfg_blank_hold : cfg_step_dly;

  prot_step_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (tmr_clr),
    .dly   (cur_dly),
    .done  (step_done)
  );

  prot_release_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .any_cause_d (any_cause_d),
    .step_done   (step_done),
    .state_q     (state_q),
    .tmr_clr     (tmr_clr),
    .hdrv_oe     (hdrv_oe),
    .bdrv_oe     (bdrv_oe),
    .vout_oe     (vout_oe),
    .unlock_oe   (unlock_oe),
    .blank_on    (blank_on),
    .dischg_on   (dischg_on)
  );

endmodule

// File: rtl/prot_seq_chk.sv
module prot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic flt_supply_low,
  input logic flt_supply_dip,
  input logic flt_xray,
  input logic flt_pll_gnd,
  input logic hdrv_oe,
  input logic bdrv_oe,
  input logic vout_oe,
  input logic unlock_oe,
  input logic blank_on,
  input logic dischg_on
);

  logic any_flt;
  assign any_flt = flt_supply_low | flt_supply_dip | flt_xray | flt_pll_gnd;

  // R2
  fault_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_flt |=> (dischg_on && blank_on && !hdrv_oe && !bdrv_oe && !vout_oe && !unlock_oe));

  // R8
  hdrv_after_dischg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrv_oe) |-> ($past(!dischg_on) && blank_on));

  // R8
  bdrv_after_hdrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bdrv_oe) |-> ($past(hdrv_oe) && !$past(bdrv_oe)));

  // R8
  vout_after_bdrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vout_oe) |-> $past(bdrv_oe));

  // R8
  unlock_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_oe) |-> ($past(vout_oe) && !blank_on));

  // R2
  no_drive_in_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dischg_on |-> ($countones({hdrv_oe, bdrv_oe, vout_oe, unlock_oe}) == 0));

endmodule

bind prot_seq prot_seq_chk u_prot_seq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flt_supply_low (flt_supply_low),
  .flt_supply_dip (flt_supply_dip),
  .flt_xray       (flt_xray),
  .flt_pll_gnd    (flt_pll_gnd),
  .hdrv_oe        (hdrv_oe),
  .bdrv_oe        (bdrv_oe),
  .vout_oe        (vout_oe),
  .unlock_oe      (unlock_oe),
  .blank_on       (blank_on),
  .dischg_on      (dischg_on)
);

// File: tb/tb_prot_seq.sv
module tb_prot_seq;

  localparam int DLY_W = 8;
  // output vector order: {dischg, blank, hdrv, bdrv, vout, unlock}
  localparam logic [5:0] O_SAFE  = 6'b110000;
  localparam logic [5:0] O_DISCH = 6'b010000;
  localparam logic [5:0] O_HDRV  = 6'b011000;
  localparam logic [5:0] O_BDRV  = 6'b011100;
  localparam logic [5:0] O_VOUT  = 6'b011110;
  localparam logic [5:0] O_RUN   = 6'b001111;

  logic clk;
  logic rst_n;
  logic f_low, f_dip, f_xray, f_pll, ss, rld;
  logic [DLY_W-1:0] hold, step;
  logic hdrv_oe, bdrv_oe, vout_oe, unlock_oe, blank_on, dischg_on;

  int checks = 0;
  int errors = 0;
  int cur_b  = 4;
  int cur_s  = 3;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  prot_seq #(.DLY_W(DLY_W)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .flt_supply_low (f_low),
    .flt_supply_dip (f_dip),
    .flt_xray       (f_xray),
    .flt_pll_gnd    (f_pll),
    .i2c_soft_start (ss),
    .regs_reloaded  (rld),
    .cfg_blank_hold (hold),
    .cfg_step_dly   (step),
    .hdrv_oe        (hdrv_oe),
    .bdrv_oe        (bdrv_oe),
    .vout_oe        (vout_oe),
    .unlock_oe      (unlock_oe),
    .blank_on       (blank_on),
    .dischg_on      (dischg_on)
  );

  function automatic logic [5:0] outs();
    return {dischg_on, blank_on, hdrv_oe, bdrv_oe, vout_oe, unlock_oe};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ss();
    ss = 1'b1; tick(1); ss = 1'b0;
  endtask

  task automatic pulse_rld();
    rld = 1'b1; tick(1); rld = 1'b0;
  endtask

  // called at the negedge right after the recovering edge
  task automatic release_walk(input string req);
    int eb, es;
    eb = (cur_b < 1) ? 1 : cur_b;
    es = (cur_s < 1) ? 1 : cur_s;
    chk(req, O_DISCH);
    if (eb > 1) begin tick(eb - 1); chk(req, O_DISCH); end
    tick(1); chk(req, O_HDRV);
    if (es > 1) begin tick(es - 1); chk(req, O_HDRV); end
    tick(1); chk(req, O_BDRV);
    if (es > 1) begin tick(es - 1); chk(req, O_BDRV); end
    tick(1); chk(req, O_VOUT);
    tick(es); chk(req, O_RUN);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; f_low = 0; f_dip = 0; f_xray = 0; f_pll = 0;
    ss = 0; rld = 0; hold = 8'd4; step = 8'd3;
    tick(3);
    chk("R1 in reset", O_SAFE);
    rst_n = 1'b1;
    tick(5);
    chk("R1 after reset", O_SAFE);
  endtask

  task automatic t_startup();
    pulse_ss(); tick(1);
    chk("R3 soft start without reload ignored", O_SAFE);
    pulse_rld(); tick(2);
    chk("R3 reload without soft start", O_SAFE);
    pulse_ss();
    release_walk("R8 startup release order");
  endtask

  task automatic t_dip_then_xray();
    f_dip = 1; tick(1);
    chk("R2 dip from run", O_SAFE);
    f_dip = 0; tick(2);
    chk("R4 dip released, no reload yet", O_SAFE);
    pulse_rld(); tick(1);
    chk("R4 dip recovers without soft start", O_DISCH);
    tick(cur_b);
    chk("R8 horizontal driver step", O_HDRV);
    f_xray = 1; tick(1);
    chk("R2 fault during release", O_SAFE);
    f_xray = 0; tick(1);
    pulse_rld(); tick(3);
    chk("R5 xray stays latched after reload", O_SAFE);
    pulse_ss();
    release_walk("R5 xray soft start release");
  endtask

  task automatic t_pll();
    f_pll = 1; tick(2);
    chk("R2 pll grounded", O_SAFE);
    f_pll = 0; tick(1);
    release_walk("R6 pll release alone");
  endtask

  task automatic t_multi();
    f_dip = 1; f_pll = 1; tick(1);
    chk("R2 two faults", O_SAFE);
    f_dip = 0; f_pll = 0; tick(3);
    chk("R7 pll released, dip still latched", O_SAFE);
    pulse_rld(); tick(1);
    chk("R7 last cause cleared", O_DISCH);
    tick(cur_b + 3 * cur_s);
    chk("R7 back to run", O_RUN);
  endtask

  task automatic t_reload_gate();
    f_low = 1; tick(1);
    chk("R2 low supply", O_SAFE);
    pulse_rld();
    f_low = 0; tick(1);
    pulse_ss(); tick(1);
    chk("R10 reload during fault not counted", O_SAFE);
    pulse_rld(); pulse_ss();
    chk("R3 low supply recovery", O_DISCH);
    tick(cur_b + 3 * cur_s);
    chk("R3 back to run", O_RUN);
  endtask

  task automatic t_zero_delay();
    hold = 8'd0; step = 8'd0; cur_b = 0; cur_s = 0;
    f_pll = 1; tick(1);
    chk("R9 fault before zero delay run", O_SAFE);
    f_pll = 0; tick(1);
    release_walk("R9 zero delays one cycle each");
    hold = 8'd4; step = 8'd3; cur_b = 4; cur_s = 3;
  endtask

  initial begin
    t_reset();
    t_startup();
    t_dip_then_xray();
    t_pll();
    t_multi();
    t_reload_gate();
    t_zero_delay();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule